// File: doc/BRIEF.md
# Down-Counting Periodic Pulse Generator

This block makes one periodic pulse train from two configuration inputs, a period length and a high-time length, both counted in clock cycles. A down-counter runs once through each period. The pulse is high during the last cycles of each period, so the rising edge of the pulse marks a fixed distance before the end of the period. The running count is driven on an output port. Neighbouring logic can use it to schedule events relative to the pulse, for example to start an action a set number of cycles before the pulse ends.

The counter samples the configuration only when it wraps. A change in the middle of a period therefore never produces a shortened or stretched pulse. Settings that make no sense fail safe. A high time longer than the period keeps the output low instead of high. A period of zero parks the counter at zero with the output low. The reset input is asynchronous and active low. Its release is re-timed through two flops, so counting starts on the third rising edge after the reset input goes high.

Top module: `pwm_downcount_gen`

## Requirements
- R1: While `rst_n` is low, `pulse` is 0 and `counter` is 0. Both outputs clear as soon as `rst_n` falls, without waiting for a clock edge.
- R2: After `rst_n` rises, the first two rising edges leave the outputs in the reset state. On the third rising edge `counter` becomes `period`-1. From then on, `counter` falls by one on each edge and goes from 0 back to the period length minus one.
- R3: `period` and `width` are captured only on an edge where `counter` shows 0. A change while `counter` is nonzero has no effect on the count sequence or on the pulse until that capture.
- R4: With captured values P (period) and W (width), `pulse` is 1 in exactly the cycles where W <= P and `counter` < W. These are the last W cycles of each period.
- R5: For 0 < W <= P, every P consecutive cycles contain exactly W high cycles. When W equals P, the output is constantly high.
- R6: When the captured W is greater than the captured P, `pulse` stays 0.
- R7: When the captured P is 0, `counter` stays at 0 and `pulse` stays 0.
- R8: When the captured W is 0, `pulse` stays 0 while `counter` keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop stage |
| period | input | CNT_W | Period length in cycles, captured at wrap |
| width | input | CNT_W | High time in cycles, captured at wrap |
| pulse | output | 1 | Registered pulse output |
| counter | output | CNT_W | Running down-count value, aligned with `pulse` |

## Verification
The hardest case to reach from the ports is a configuration change that arrives while a period is half done. The old values must keep running until the wrap, and the new ones must take effect on exactly the next edge. The stimulus watches `counter` until it reaches a known midpoint and changes both inputs there. It then checks the next count value and the first value after the wrap. A behavioural reference model, compared every cycle, covers the same transition for every other setting change. Asserting reset while the output is high confirms that the clear is asynchronous.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Default counter width for the generator.
  parameter int unsigned PWM_CNT_W_DEF = 8;

  // Operation chosen by the counter next-state logic each cycle.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,  // parked at zero (period of zero captured)
    CNT_LOAD = 2'd1,  // wrap: reload with period minus one
    CNT_DEC  = 2'd2   // normal decrement
  } pwm_cnt_op_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign run_n = stage_q[1];

endmodule

// File: rtl/pwm_cfg_hold.sv
module pwm_cfg_hold #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] width_in,
  output logic [CNT_W-1:0] per_d,
  output logic [CNT_W-1:0] wid_d,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] wid_q
);

  // Next-state: take the new configuration only at a wrap.
  always_comb begin
    per_d = per_q;
    wid_d = wid_q;
    if (load_en) begin
      per_d = period_in;
      wid_d = width_in;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      per_q <= '0;
      wid_q <= '0;
    end else if (load_en) begin
      per_q <= per_d;
      wid_q <= wid_d;
    end
  end

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic [CNT_W-1:0] period_in,
  output logic             load_en,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] cnt_q
);

  import pwm_pkg::*;

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  pwm_cnt_op_e op;

  assign load_en = (cnt_q == ZERO);

  always_comb begin
    if (load_en) begin
      op = (period_in == ZERO) ? CNT_HOLD : CNT_LOAD;
    end else begin
      op = CNT_DEC;
    end
  end

  always_comb begin
    unique case (op)
      CNT_LOAD: cnt_d = period_in - ONE;
      CNT_DEC:  cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pwm_pulse_stage.sv
module pwm_pulse_stage #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             run_n,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] per_d,
  input  logic [CNT_W-1:0] wid_d,
  output logic             pulse_q
);

  logic fits_d;
  logic tail_d;
  logic pulse_d;

  // Evaluated on next-state values so the registered pulse lines up with
  // the registered counter in the same cycle.
  always_comb begin
    fits_d  = (wid_d <= per_d);
    tail_d  = (cnt_d < wid_d);
    pulse_d = fits_d & tail_d;
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

endmodule

// File: rtl/pwm_downcount_gen.sv
module pwm_downcount_gen #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] width,
  output logic             pulse,
  output logic [CNT_W-1:0] counter
);

  logic             run_n;
  logic             load_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_d;
  logic [CNT_W-1:0] wid_d;
  logic [CNT_W-1:0] act_period;
  logic [CNT_W-1:0] act_width;
  logic             pulse_q;

  pwm_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .run_n     (run_n),
    .period_in (period),
    .load_en   (load_en),
    .cnt_d     (cnt_d),
    .cnt_q     (cnt_q)
  );

  pwm_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
    .clk       (clk),
    .run_n     (run_n),
    .load_en   (load_en),
    .period_in (period),
    .width_in  (width),
    .per_d     (per_d),
    .wid_d     (wid_d),
    .per_q     (act_period),
    .wid_q     (act_width)
  );

  pwm_pulse_stage #(.CNT_W(CNT_W)) u_pulse (
    .clk     (clk),
    .run_n   (run_n),
    .cnt_d   (cnt_d),
    .per_d   (per_d),
    .wid_d   (wid_d),
    .pulse_q (pulse_q)
  );

  assign pulse   = pulse_q;
  assign counter = cnt_q;

endmodule

// File: rtl/pwm_downcount_gen_chk.sv
module pwm_downcount_gen_chk #(
  parameter int unsigned CNT_W = pwm_pkg::PWM_CNT_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_n,
  input logic             pulse,
  input logic [CNT_W-1:0] counter,
  input logic [CNT_W-1:0] act_period,
  input logic [CNT_W-1:0] act_width
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R1: outputs quiet in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!pulse && counter == '0);
    end
  end

  // R2: nonzero count steps down by one
  assert_decrement_R2: assert property (@(posedge clk) disable iff (!run_n)
    (counter != '0) |=> (counter == $past(counter) - ONE));

  // R3: wrap reloads from the captured period
  assert_reload_R3: assert property (@(posedge clk) disable iff (!run_n)
    (counter == '0) |=> ((act_period == '0) ? (counter == '0)
                                             : (counter == act_period - ONE)));

  // R3: configuration frozen mid-period
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!run_n)
    (counter != '0) |=> ($stable(act_period) && $stable(act_width)));

  // R4: pulse only in the tail window
  assert_pulse_window_R4: assert property (@(posedge clk) disable iff (!run_n)
    pulse |-> (counter < act_width));

  // R5: tail window is always filled when width fits
  assert_pulse_fill_R5: assert property (@(posedge clk) disable iff (!run_n)
    ((act_width <= act_period) && (counter < act_width)) |-> pulse);

  // R6: oversize width keeps output low
  assert_wide_low_R6: assert property (@(posedge clk) disable iff (!run_n)
    (act_width > act_period) |-> !pulse);

  // R7: zero period parks the counter
  assert_zero_period_R7: assert property (@(posedge clk) disable iff (!run_n)
    (act_period == '0) |-> (counter == '0 && !pulse));

endmodule

bind pwm_downcount_gen pwm_downcount_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_n      (run_n),
  .pulse      (pulse),
  .counter    (counter),
  .act_period (act_period),
  .act_width  (act_width)
);

// File: tb/pwm_downcount_gen_test.sv
module pwm_downcount_gen_test;

  localparam int CW = 8;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] period;
  logic [CW-1:0] width;
  logic          pulse;
  logic [CW-1:0] counter;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 0;
  bit done   = 0;

  // reference model state
  int m_stage = 0;
  int m_cnt   = 0;
  int m_per   = 0;
  int m_wid   = 0;
  int m_pulse = 0;

  pwm_downcount_gen #(.CNT_W(CW)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (period),
    .width   (width),
    .pulse   (pulse),
    .counter (counter)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, stepped on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stage = 0; m_cnt = 0; m_per = 0; m_wid = 0; m_pulse = 0;
    end else if (m_stage < 2) begin
      m_stage++;
    end else begin
      if (m_cnt == 0) begin
        m_per = int'(period);
        m_wid = int'(width);
        m_cnt = (m_per == 0) ? 0 : m_per - 1;
      end else begin
        m_cnt = m_cnt - 1;
      end
      m_pulse = (m_cnt < m_wid && m_wid <= m_per) ? 1 : 0;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(int'(counter) == m_cnt, "R2 counter vs model", int'(counter), m_cnt);
      check(int'(pulse) == m_pulse, "R4 pulse vs model", int'(pulse), m_pulse);
    end
  end

  task automatic set_cfg(input int p, input int w);
    @(negedge clk); #1;
    period = CW'(p);
    width  = CW'(w);
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      hi += int'(pulse);
    end
  endtask

  initial begin
    int hi;
    bit ok;
    rst_n  = 1'b0;
    period = CW'(10);
    width  = CW'(3);

    // R1: reset state held over several cycles
    ok = 1;
    repeat (4) begin
      @(negedge clk);
      if (pulse !== 1'b0 || counter !== '0) ok = 0;
    end
    check(ok, "R1 reset state", int'(counter), 0);
    cmp_en = 1;

    // R2: release timing
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(counter == '0, "R2 first edge still idle", int'(counter), 0);
    @(negedge clk);
    check(counter == '0, "R2 second edge still idle", int'(counter), 0);
    @(negedge clk);
    check(counter == CW'(9), "R2 load period-1", int'(counter), 9);
    @(negedge clk);
    check(counter == CW'(8), "R2 decrement", int'(counter), 8);

    // R5: 3 high per 10 cycles
    repeat (12) @(negedge clk);
    count_high(40, hi);
    check(hi == 12, "R5 high count P10 W3", hi, 12);

    // R3: change in mid-period
    while (counter != CW'(5)) @(negedge clk);
    #1 period = CW'(6); width = CW'(2);
    @(negedge clk);
    check(counter == CW'(4), "R3 mid-period change ignored", int'(counter), 4);
    while (counter != '0) @(negedge clk);
    @(negedge clk);
    check(counter == CW'(5), "R3 new period at wrap", int'(counter), 5);
    count_high(24, hi);
    check(hi == 8, "R5 high count P6 W2", hi, 8);

    // R5: width equals period -> constant high
    set_cfg(4, 4);
    repeat (14) @(negedge clk);
    count_high(16, hi);
    check(hi == 16, "R5 width equals period", hi, 16);

    // R6: width above period -> low
    set_cfg(5, 7);
    repeat (12) @(negedge clk);
    count_high(20, hi);
    check(hi == 0, "R6 oversize width low", hi, 0);

    // R8: width zero -> low, counter runs
    set_cfg(5, 0);
    repeat (12) @(negedge clk);
    count_high(20, hi);
    check(hi == 0, "R8 zero width low", hi, 0);
    while (counter != CW'(4)) @(negedge clk);
    @(negedge clk);
    check(counter == CW'(3), "R8 counter still runs", int'(counter), 3);

    // R7: zero period parks counter
    set_cfg(0, 0);
    repeat (12) @(negedge clk);
    ok = 1;
    repeat (10) begin
      @(negedge clk);
      if (counter != '0 || pulse != 1'b0) ok = 0;
    end
    check(ok, "R7 zero period parked", int'(counter), 0);
    set_cfg(0, 3);
    repeat (4) @(negedge clk);
    count_high(10, hi);
    check(hi == 0, "R6 zero period with width 3", hi, 0);

    // R5: period 1 width 1 -> constant high
    set_cfg(1, 1);
    repeat (4) @(negedge clk);
    count_high(10, hi);
    check(hi == 10, "R5 period 1 width 1", hi, 10);

    // R1: asynchronous clear while high
    @(negedge clk); #1 rst_n = 1'b0;
    #2;
    check(pulse == 1'b0, "R1 async clear pulse", int'(pulse), 0);
    check(counter == '0, "R1 async clear counter", int'(counter), 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    set_cfg(7, 2);
    repeat (20) @(negedge clk);
    count_high(21, hi);
    check(hi == 6, "R5 high count after re-reset", hi, 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule